// File: doc/BRIEF.md
# CAN transmit abort synchronizer

This block sits between a processor's register bits and a simplified CAN transmit engine. It makes sure that a request to abort a frame can only take effect outside a critical window. The window covers the last two bit times of a frame, just before the internal transmit request would clear on its own.

Software first sets a sync-request bit. The block grants it, and the bit reads back as 1, only when the transmitter is outside the critical window. A request made inside the window is held until the window ends, which is at most two bit times. Setting the bit never puts anything on the transmit line.

With the sync bit granted, software clears the buffer lock bit. The block then withdraws the internal transmit request, returns the line to recessive and pulses an abort-done flag. Reading the lock bit back as 0 tells software the abort is complete. If the lock clear arrives before the sync bit is granted, or inside the window, it is held pending and applied at the first safe point. A new frame starts only from a locked buffer while the sync bit is clear.

Top module: `can_txa_sync`

## Requirements
- R1: After reset, `sync_rd`, `lock_rd`, `tx_req`, `abort_done` and `tx_done` are 0, and `tx_line` is 1 (recessive).
- R2: A write of 1 to the lock bit sets `lock_rd` on the next clock. If the sync bit is clear and no sync is pending, `tx_req` rises one clock later and `tx_payload` is sent MSB first on `tx_line`, each bit lasting `bit_div`+1 clocks.
- R3: A frame that is not aborted lasts FRAME_BITS bit times. At its end `tx_req` and `lock_rd` fall together and `tx_done` pulses high for exactly one clock.
- R4: A write of 1 to the sync bit outside the critical window makes `sync_rd` read 1 on the next clock.
- R5: The critical window is the last two bit times of a frame. A sync write made inside it leaves `sync_rd` at 0 until the frame has ended, and it is granted on the clock after the end. This is within two bit times of the write, and a grant never follows a cycle spent inside the window.
- R6: Writing the sync bit never drives `tx_line` low. While `tx_req` is 0, `tx_line` stays 1.
- R7: Clearing the lock bit while `sync_rd` is 1 and the transmitter is outside the window is accepted on the next clock. `lock_rd` and `tx_req` drop, `tx_line` returns to 1, and `abort_done` pulses high for exactly one clock.
- R8: Clearing the lock bit while the sync bit is not yet granted leaves `lock_rd` and `tx_req` at 1. The clear is applied on the clock after the sync grant.
- R9: While the sync bit is set, no new frame starts even with the lock set. Writing 0 to the sync bit clears `sync_rd` on the next clock, and a locked buffer then starts one clock later.
- R10: `tx_req` never rises while the lock bit is 0. After an abort, clearing the sync bit alone does not start a frame.
- R11: A lock clear made inside the critical window with the sync bit granted is held. The frame then ends normally with `tx_done` and without `abort_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_div | input | DIV_W | Clocks per bit minus one |
| tx_payload | input | FRAME_BITS | Frame contents, sampled at frame start, sent MSB first |
| sync_wr | input | 1 | Write strobe for the sync-request bit |
| sync_wdata | input | 1 | Value written to the sync-request bit |
| lock_wr | input | 1 | Write strobe for the buffer lock bit |
| lock_wdata | input | 1 | Value written to the buffer lock bit |
| sync_rd | output | 1 | Read-back of the sync bit (1 once granted) |
| lock_rd | output | 1 | Read-back of the buffer lock bit |
| tx_req | output | 1 | Internal transmit request, high while a frame is on the line |
| tx_line | output | 1 | Transmit line, 1 is recessive |
| abort_done | output | 1 | One-clock pulse when an abort is accepted |
| tx_done | output | 1 | One-clock pulse when a frame ends normally |

## Verification
The assertions assume that `bit_div` stays constant while a frame is on the line, and that reset is held for at least one clock. Under those conditions the window tracking and the one-clock pulses are well defined. The stimulus sets `bit_div` once before reset is released. Writes are applied for a single clock, and at least one idle clock separates writes to the same bit, so every grant and every acceptance point can be told apart. Each sync or lock write is placed at a known bit position of a frame, either clearly outside the last two bit times or clearly inside them.

// File: rtl/can_txa_pkg.sv
// Package: shared types for the CAN transmit abort synchronizer.
// Assumes nothing beyond IEEE 1800-2017 packed structs.
package can_txa_pkg;

    // One register-bit write: strobe plus value.
    typedef struct packed {
        logic req;
        logic val;
    } bit_wr_t;

    // Number of bit times that make up the critical window.
    localparam int unsigned CRIT_BITS = 2;

endpackage

// File: rtl/can_txa_bit_timer.sv
// Bit timer: counts system clocks per bit and bit positions within a frame.
// It reports bit boundaries, the end of a frame and whether the frame is in
// its critical window (the last CRIT_BITS bit times).
// Assumes bit_div is held constant while busy and FRAME_BITS > CRIT_BITS.
module can_txa_bit_timer #(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned DIV_W      = 8,
    parameter int unsigned CRIT_BITS  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] bit_div,
    input  logic             start,
    input  logic             stop,
    output logic             busy,
    output logic             bit_end,
    output logic             frame_end,
    output logic             in_crit
);
    localparam int unsigned IDX_W      = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
    localparam int unsigned LAST_IDX   = FRAME_BITS - 1;
    localparam int unsigned CRIT_START = FRAME_BITS - CRIT_BITS;

    logic [DIV_W-1:0] div_cnt;
    logic [IDX_W-1:0] bit_idx;
    logic             last_bit;

    // Decode the bit boundary, the last bit and the critical window.
    always_comb begin
        bit_end   = busy && (div_cnt == bit_div);
        last_bit  = (bit_idx == IDX_W'(LAST_IDX));
        frame_end = bit_end && last_bit && !stop;
        in_crit   = busy && (bit_idx >= IDX_W'(CRIT_START));
    end

    // Advance the clock divider and the bit index while a frame runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            div_cnt <= '0;
            bit_idx <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            div_cnt <= '0;
            bit_idx <= '0;
        end else if (busy) begin
            if (stop) begin
                busy    <= 1'b0;
                div_cnt <= '0;
                bit_idx <= '0;
            end else if (bit_end) begin
                div_cnt <= '0;
                if (last_bit) begin
                    busy    <= 1'b0;
                    bit_idx <= '0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/can_txa_shifter.sv
// Frame shifter: loads the payload at frame start and presents it MSB first
// on the transmit line, one bit per bit time. The line is recessive (1)
// whenever no frame is active.
// Assumes load and shift are never asserted in the same cycle.
module can_txa_shifter #(
    parameter int unsigned FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  shift,
    input  logic                  active,
    input  logic [FRAME_BITS-1:0] payload,
    output logic                  line
);
    localparam int unsigned MSB = FRAME_BITS - 1;

    logic [FRAME_BITS-1:0] shreg;

    // Hold the frame and move it up one place per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
        end else if (load) begin
            shreg <= payload;
        end else if (shift) begin
            shreg <= {shreg[MSB-1:0], 1'b1};
        end
    end

    // Drive the current bit only while a frame is active.
    always_comb begin
        line = active ? shreg[MSB] : 1'b1;
    end

endmodule

// File: rtl/can_txa_abort_ctrl.sv
// Abort controller: owns the sync-request and lock bits. It grants sync only
// outside the critical window, holds lock clears until they are safe, issues
// frame start and stop, and pulses completion flags.
// Assumes writes are single-cycle strobes from the register interface.
module can_txa_abort_ctrl
    import can_txa_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  bit_wr_t sync_w,
    input  bit_wr_t lock_w,
    input  logic    busy,
    input  logic    in_crit,
    input  logic    frame_end,
    output logic    start,
    output logic    stop,
    output logic    sync_q,
    output logic    lock_q,
    output logic    abort_done,
    output logic    tx_done
);
    logic sync_pend;
    logic clr_pend;
    logic clr_now;
    logic set_now;
    logic accept;

    // Decode writes, abort acceptance and frame start.
    always_comb begin
        clr_now = lock_w.req && !lock_w.val;
        set_now = lock_w.req && lock_w.val;
        accept  = lock_q && sync_q && !in_crit && (clr_now || clr_pend);
        stop    = accept && busy;
        start   = lock_q && !sync_q && !sync_pend && !clr_pend && !busy;
    end

    // Sync-request bit: grant outside the window, otherwise defer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q    <= 1'b0;
            sync_pend <= 1'b0;
        end else if (sync_w.req) begin
            if (!sync_w.val) begin
                sync_q    <= 1'b0;
                sync_pend <= 1'b0;
            end else if (!in_crit) begin
                sync_q    <= 1'b1;
                sync_pend <= 1'b0;
            end else begin
                sync_pend <= 1'b1;
            end
        end else if (sync_pend && !in_crit) begin
            sync_q    <= 1'b1;
            sync_pend <= 1'b0;
        end
    end

    // Lock bit: set by software, cleared at frame end or on an accepted abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q   <= 1'b0;
            clr_pend <= 1'b0;
        end else if (frame_end || accept) begin
            lock_q   <= 1'b0;
            clr_pend <= 1'b0;
        end else if (set_now) begin
            lock_q   <= 1'b1;
            clr_pend <= 1'b0;
        end else if (clr_now && lock_q) begin
            clr_pend <= 1'b1;
        end
    end

    // One-clock completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_done <= 1'b0;
            tx_done    <= 1'b0;
        end else begin
            abort_done <= accept;
            tx_done    <= frame_end;
        end
    end

endmodule

// File: rtl/can_txa_sync.sv
// Top: CAN transmit abort synchronizer. It ties the register bits and the
// abort controller to a bit timer and a frame shifter that stand in for the
// transmit engine.
// Assumes bit_div is static during a frame.
module can_txa_sync
    import can_txa_pkg::*;
#(
    parameter int unsigned FRAME_BITS = 16,
    parameter int unsigned DIV_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [DIV_W-1:0]      bit_div,
    input  logic [FRAME_BITS-1:0] tx_payload,
    input  logic                  sync_wr,
    input  logic                  sync_wdata,
    input  logic                  lock_wr,
    input  logic                  lock_wdata,
    output logic                  sync_rd,
    output logic                  lock_rd,
    output logic                  tx_req,
    output logic                  tx_line,
    output logic                  abort_done,
    output logic                  tx_done
);
    bit_wr_t sync_w;
    bit_wr_t lock_w;
    logic    busy;
    logic    bit_end;
    logic    frame_end;
    logic    in_crit;
    logic    start;
    logic    stop;

    // Bundle the register writes.
    always_comb begin
        sync_w = '{req: sync_wr, val: sync_wdata};
        lock_w = '{req: lock_wr, val: lock_wdata};
    end

    can_txa_bit_timer #(
        .FRAME_BITS(FRAME_BITS),
        .DIV_W     (DIV_W),
        .CRIT_BITS (CRIT_BITS)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_div  (bit_div),
        .start    (start),
        .stop     (stop),
        .busy     (busy),
        .bit_end  (bit_end),
        .frame_end(frame_end),
        .in_crit  (in_crit)
    );

    can_txa_shifter #(
        .FRAME_BITS(FRAME_BITS)
    ) shift_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .shift  (bit_end),
        .active (busy),
        .payload(tx_payload),
        .line   (tx_line)
    );

    can_txa_abort_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_w    (sync_w),
        .lock_w    (lock_w),
        .busy      (busy),
        .in_crit   (in_crit),
        .frame_end (frame_end),
        .start     (start),
        .stop      (stop),
        .sync_q    (sync_rd),
        .lock_q    (lock_rd),
        .abort_done(abort_done),
        .tx_done   (tx_done)
    );

    // The transmit request is high for as long as a frame runs.
    always_comb begin
        tx_req = busy;
    end

endmodule

// File: rtl/can_txa_sync_chk.sv
// Checker: temporal properties of the abort synchronizer, bound to the top.
// Assumes reset is held for at least one clock before release.
module can_txa_sync_chk (
    input logic clk,
    input logic rst_n,
    input logic sync_rd,
    input logic lock_rd,
    input logic tx_req,
    input logic tx_line,
    input logic abort_done,
    input logic tx_done,
    input logic in_crit
);
    AST_TXDONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done); // R3
    AST_TXDONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!tx_req && !lock_rd)); // R3
    AST_SYNC_SAFE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_rd) |-> !$past(in_crit)); // R5
    AST_IDLE_RECESSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |-> tx_line); // R6
    AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |=> !abort_done); // R7
    AST_ABORT_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |-> ($past(sync_rd) && !lock_rd && !tx_req)); // R7
    AST_NO_START_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_rd && !tx_req) |=> !tx_req); // R9
    AST_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_req) |-> lock_rd); // R10
    AST_ABORT_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        abort_done |-> !$past(in_crit)); // R11
endmodule

bind can_txa_sync can_txa_sync_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_rd   (sync_rd),
    .lock_rd   (lock_rd),
    .tx_req    (tx_req),
    .tx_line   (tx_line),
    .abort_done(abort_done),
    .tx_done   (tx_done),
    .in_crit   (in_crit)
);

// File: tb/can_txa_sync_tb_top.sv
// Bench: scoreboard of expected completion pulses plus direct port checks.
module can_txa_sync_tb_top;
    localparam int unsigned FB = 16;
    localparam int unsigned DW = 8;

    typedef enum logic {EV_TXDONE, EV_ABORT} ev_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] bit_div = 8'd3;
    logic [FB-1:0] tx_payload = '0;
    logic          sync_wr = 1'b0, sync_wdata = 1'b0;
    logic          lock_wr = 1'b0, lock_wdata = 1'b0;
    logic          sync_rd, lock_rd, tx_req, tx_line, abort_done, tx_done;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    ev_t exp_q[$];

    always #2.5 clk = ~clk;

    can_txa_sync #(.FRAME_BITS(FB), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bit_div(bit_div), .tx_payload(tx_payload),
        .sync_wr(sync_wr), .sync_wdata(sync_wdata),
        .lock_wr(lock_wr), .lock_wdata(lock_wdata),
        .sync_rd(sync_rd), .lock_rd(lock_rd), .tx_req(tx_req),
        .tx_line(tx_line), .abort_done(abort_done), .tx_done(tx_done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic expect_ev(input ev_t e);
        exp_q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_sync(input logic v);
        sync_wr = 1'b1; sync_wdata = v;
        step(1);
        sync_wr = 1'b0;
    endtask

    task automatic wr_lock(input logic v);
        lock_wr = 1'b1; lock_wdata = v;
        step(1);
        lock_wr = 1'b0;
    endtask

    // Monitor: pop the expected pulse and compare with the observed one.
    always @(negedge clk) begin
        if (rst_n && (tx_done || abort_done)) begin
            ev_t got;
            got = tx_done ? EV_TXDONE : EV_ABORT;
            n_checks++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R3/R7 unexpected pulse act=%0d exp=none", got);
            end else begin
                ev_t want;
                want = exp_q.pop_front();
                if (got != want) begin
                    n_fail++;
                    $display("FAIL %s pulse act=%0d exp=%0d",
                             (want == EV_ABORT) ? "R7" : "R3", got, want);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 sync", 32'(sync_rd), 0);
        check("R1 lock", 32'(lock_rd), 0);
        check("R1 req", 32'(tx_req), 0);
        check("R1 pulses", 32'({abort_done, tx_done}), 0);
        check("R1 line", 32'(tx_line), 1);

        // R4/R6: sync while idle grants next clock, line stays recessive
        wr_sync(1'b1);
        check("R4 grant", 32'(sync_rd), 1);
        for (int i = 0; i < 4; i++) begin
            check("R6 line", 32'(tx_line), 1);
            step(1);
        end
        wr_sync(1'b0);
        check("R9 sync clear", 32'(sync_rd), 0);

        // R2/R3: normal frame
        tx_payload = 16'hA5C3;
        wr_lock(1'b1);
        check("R2 lock", 32'(lock_rd), 1);
        check("R2 req late", 32'(tx_req), 0);
        step(1);
        check("R2 req", 32'(tx_req), 1);
        expect_ev(EV_TXDONE);
        for (int i = 0; i < 16; i++) begin
            check("R2 bit", 32'(tx_line), 32'(tx_payload[15-i]));
            step(4);
        end
        check("R3 req end", 32'(tx_req), 0);
        check("R3 lock end", 32'(lock_rd), 0);
        step(2);

        // R7/R9: sync outside window, then abort
        tx_payload = 16'h0F0F;
        wr_lock(1'b1);
        step(1);
        step(10);
        wr_sync(1'b1);
        check("R4 grant busy", 32'(sync_rd), 1);
        check("R4 still busy", 32'(tx_req), 1);
        expect_ev(EV_ABORT);
        wr_lock(1'b0);
        check("R7 lock", 32'(lock_rd), 0);
        check("R7 req", 32'(tx_req), 0);
        check("R7 line", 32'(tx_line), 1);
        step(2);
        wr_lock(1'b1);
        step(5);
        check("R9 no start", 32'(tx_req), 0);
        wr_sync(1'b0);
        check("R9 sync off", 32'(sync_rd), 0);
        check("R9 not yet", 32'(tx_req), 0);
        step(1);
        check("R9 restart", 32'(tx_req), 1);
        expect_ev(EV_TXDONE);
        step(64);
        check("R3 req end2", 32'(tx_req), 0);
        step(2);

        // R5: sync inside window is deferred
        wr_lock(1'b1);
        step(1);
        expect_ev(EV_TXDONE);
        step(57);
        wr_sync(1'b1);
        check("R5 deferred", 32'(sync_rd), 0);
        step(6);
        check("R5 frame end", 32'(tx_req), 0);
        check("R5 still 0", 32'(sync_rd), 0);
        step(1);
        check("R5 granted", 32'(sync_rd), 1);
        wr_sync(1'b0);
        step(2);

        // R8/R10: lock clear before grant is held
        wr_lock(1'b1);
        step(1);
        step(10);
        wr_lock(1'b0);
        check("R8 lock held", 32'(lock_rd), 1);
        check("R8 req held", 32'(tx_req), 1);
        wr_sync(1'b1);
        check("R8 sync", 32'(sync_rd), 1);
        check("R8 lock still", 32'(lock_rd), 1);
        expect_ev(EV_ABORT);
        step(1);
        check("R8 applied lock", 32'(lock_rd), 0);
        check("R8 applied req", 32'(tx_req), 0);
        wr_sync(1'b0);
        step(6);
        check("R10 no start unlocked", 32'(tx_req), 0);

        // R11: lock clear inside window with sync granted
        wr_lock(1'b1);
        step(1);
        step(10);
        wr_sync(1'b1);
        step(46);
        wr_lock(1'b0);
        check("R11 lock held", 32'(lock_rd), 1);
        check("R11 req held", 32'(tx_req), 1);
        expect_ev(EV_TXDONE);
        step(6);
        check("R11 lock end", 32'(lock_rd), 0);
        check("R11 req end", 32'(tx_req), 0);
        wr_sync(1'b0);
        step(4);

        check("R3/R7 queue empty", 32'(exp_q.size()), 0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule